// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Controller

This block steers a five-stage in-order integer pipeline around two kinds of hazard. A load in the execute stage whose result is needed by the instruction now in decode cannot be served by forwarding in time. For that case the controller freezes the program counter and the fetch/decode register for one cycle. In that same cycle it feeds an all-zero control word into the decode/execute register, so the slot behind the load becomes a harmless bubble.

Branches are resolved in decode. The outside decoder supplies a branch flag and the result of comparing the two register operands for equality. Fetch proceeds sequentially under a predict-not-taken policy. When a branch in decode turns out taken, the controller raises a fetch flush, and the instruction fetched in that cycle is replaced by a nop in the fetch/decode register. A taken branch therefore costs exactly one slot.

The block holds the fetch/decode and decode/execute pipeline registers itself, so that bubbles and flushes can be seen at its ports. The register file, ALU, memories and forwarding muxes are outside it.

Top module: `hazard_ctl_top`

## Requirements
- R1: A stall is raised in the cycle where the execute-stage control word has its memory-read bit set (bit 1 of `de_ctrl`) and `de_rt` equals either source field of `fd_instr`. The first source field is bits [25:21] and the second is bits [20:16]. A stall drives `pc_we` and `fd_we` low and `de_ctrl_zero` high.
- R2: After a stall cycle, `fd_instr` still holds the instruction it held during the stall.
- R3: After a stall cycle, `de_ctrl` is all zero, whatever value `dec_ctrl` had.
- R4: A load followed directly by a dependent instruction produces exactly one bubble. The cycle after a stall never stalls again.
- R5: No stall occurs when the execute-stage instruction does not read memory, or when its `de_rt` matches neither source field. In those cases `fd_instr` advances to `fetch_instr` and `de_ctrl` takes `dec_ctrl`.
- R6: With `dec_branch` low, or with `dec_regs_eq` low, `if_flush` stays low and fetch continues sequentially.
- R7: With `dec_branch` and `dec_regs_eq` both high and no stall, `if_flush` is high and `pc_we` stays high. In the next cycle `fd_instr` is the nop encoding, all zeros. The flush removes exactly one slot.
- R8: A `de_rt` of zero never causes a stall, even when a memory-read instruction names register zero in a matching field.
- R9: When a stall and a taken branch coincide, the stall wins and `if_flush` stays low. The branch is taken on the following cycle.
- R10: After reset, `fd_instr` and `de_ctrl` are zero, `pc_we` and `fd_we` are high, and `de_ctrl_zero` and `if_flush` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_instr | input | 32 | Instruction arriving from fetch |
| dec_ctrl | input | 8 | Control word decoded from `fd_instr` (bit0 reg write, bit1 memory read, bit2 memory write, bit3 memory-to-register, bit4 immediate operand, bit5 destination select, bits7:6 ALU op) |
| dec_branch | input | 1 | Decode instruction is a branch-on-equal |
| dec_regs_eq | input | 1 | The two decode-stage register operands are equal |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode register write enable |
| de_ctrl_zero | output | 1 | Select an all-zero control word into the decode/execute register |
| if_flush | output | 1 | Replace the fetched instruction with a nop |
| fd_instr | output | 32 | Fetch/decode register contents |
| de_ctrl | output | 8 | Decode/execute control word |
| de_rs | output | 5 | Decode/execute first source register |
| de_rt | output | 5 | Decode/execute second source / load destination register |
| de_rd | output | 5 | Decode/execute destination register |

## Verification
The stall and flush outputs are combinational from the current register contents and the decode inputs. They are therefore due in the same cycle, and the bench reads them a short settle time after driving the inputs, before the next edge. The effects on `fd_instr` and `de_ctrl` are due one edge later: freeze, bubble, nop or advance. Each check of those is made just after that single edge, and a bubble or flush is counted slot by slot over the following edges. This shows that a dependent load costs one slot, a non-dependent one costs none, and a taken branch removes one.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int INSTR_W  = 32;
  localparam int REG_W    = 5;
  localparam int CTRL_W   = 8;
  localparam int RS_LSB   = 21;
  localparam int RT_LSB   = 16;
  localparam int RD_LSB   = 11;
  localparam int MEMRD_BIT = 1;
  localparam int N_SRC    = 2;

  localparam logic [INSTR_W-1:0] NOP_WORD  = '0;
  localparam logic [CTRL_W-1:0]  ZERO_CTRL = '0;

  function automatic logic [REG_W-1:0] fld_rs(input logic [INSTR_W-1:0] w);
    return w[RS_LSB +: REG_W];
  endfunction

  function automatic logic [REG_W-1:0] fld_rt(input logic [INSTR_W-1:0] w);
    return w[RT_LSB +: REG_W];
  endfunction

  function automatic logic [REG_W-1:0] fld_rd(input logic [INSTR_W-1:0] w);
    return w[RD_LSB +: REG_W];
  endfunction

  // Register zero is never written, so it cannot carry a dependence.
  function automatic logic dep_match(input logic [REG_W-1:0] dst,
                                     input logic [REG_W-1:0] src);
    return (dst != '0) && (dst == src);
  endfunction
endpackage

// File: rtl/hz_loaduse.sv
module hz_loaduse
  import hz_pkg::*;
#(
  parameter int NSRC = N_SRC,
  parameter int RW   = REG_W
) (
  input  logic                     ex_mem_rd,
  input  logic [RW-1:0]            ex_dst,
  input  logic [NSRC-1:0][RW-1:0]  dec_src,
  output logic [NSRC-1:0]          src_hit,
  output logic                     hit
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_hit[g] = ex_mem_rd && dep_match(ex_dst, dec_src[g]);
  end

  assign hit = |src_hit;
endmodule

// File: rtl/hz_branch.sv
module hz_branch (
  input  logic is_branch,
  input  logic regs_eq,
  input  logic stall,
  output logic take_raw,
  output logic flush
);
  assign take_raw = is_branch && regs_eq;
  // The stall has priority: the operand may still be on its way from memory.
  assign flush    = take_raw && !stall;
endmodule

// File: rtl/hz_fd_reg.sv
module hz_fd_reg
  import hz_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          flush,
  input  logic [IW-1:0] d,
  output logic [IW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (flush) q <= '0;
    else if (we)    q <= d;
  end
endmodule

// File: rtl/hz_de_reg.sv
module hz_de_reg
  import hz_pkg::*;
#(
  parameter int CW = CTRL_W,
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zero_ctrl,
  input  logic [CW-1:0] ctrl_in,
  input  logic [RW-1:0] rs_in,
  input  logic [RW-1:0] rt_in,
  input  logic [RW-1:0] rd_in,
  output logic [CW-1:0] ctrl_q,
  output logic [RW-1:0] rs_q,
  output logic [RW-1:0] rt_q,
  output logic [RW-1:0] rd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rs_q   <= '0;
      rt_q   <= '0;
      rd_q   <= '0;
    end else begin
      ctrl_q <= zero_ctrl ? '0 : ctrl_in;
      rs_q   <= rs_in;
      rt_q   <= rt_in;
      rd_q   <= rd_in;
    end
  end
endmodule

// File: rtl/hazard_ctl_top.sv
module hazard_ctl_top
  import hz_pkg::*;
#(
  parameter int IW = INSTR_W,
  parameter int CW = CTRL_W,
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] fetch_instr,
  input  logic [CW-1:0] dec_ctrl,
  input  logic          dec_branch,
  input  logic          dec_regs_eq,
  output logic          pc_we,
  output logic          fd_we,
  output logic          de_ctrl_zero,
  output logic          if_flush,
  output logic [IW-1:0] fd_instr,
  output logic [CW-1:0] de_ctrl,
  output logic [RW-1:0] de_rs,
  output logic [RW-1:0] de_rt,
  output logic [RW-1:0] de_rd
);
  // Named internal events, visible to the checker.
  logic                   stall_w;
  logic                   take_raw_w;
  logic                   flush_w;
  logic [N_SRC-1:0]       src_hit_w;
  logic [N_SRC-1:0][RW-1:0] dec_src_w;
  logic                   ex_mem_rd_w;

  assign dec_src_w[0] = fld_rs(fd_instr);
  assign dec_src_w[1] = fld_rt(fd_instr);
  assign ex_mem_rd_w  = de_ctrl[MEMRD_BIT];

  hz_loaduse #(.NSRC(N_SRC), .RW(RW)) u_lu (
    .ex_mem_rd (ex_mem_rd_w),
    .ex_dst    (de_rt),
    .dec_src   (dec_src_w),
    .src_hit   (src_hit_w),
    .hit       (stall_w)
  );

  hz_branch u_br (
    .is_branch (dec_branch),
    .regs_eq   (dec_regs_eq),
    .stall     (stall_w),
    .take_raw  (take_raw_w),
    .flush     (flush_w)
  );

  assign pc_we        = !stall_w;
  assign fd_we        = !stall_w;
  assign de_ctrl_zero = stall_w;
  assign if_flush     = flush_w;

  hz_fd_reg #(.IW(IW)) u_fd (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fd_we),
    .flush (flush_w),
    .d     (fetch_instr),
    .q     (fd_instr)
  );

  hz_de_reg #(.CW(CW), .RW(RW)) u_de (
    .clk       (clk),
    .rst_n     (rst_n),
    .zero_ctrl (de_ctrl_zero),
    .ctrl_in   (dec_ctrl),
    .rs_in     (dec_src_w[0]),
    .rt_in     (dec_src_w[1]),
    .rd_in     (fld_rd(fd_instr)),
    .ctrl_q    (de_ctrl),
    .rs_q      (de_rs),
    .rt_q      (de_rt),
    .rd_q      (de_rd)
  );
endmodule

// File: rtl/hz_checker.sv
module hz_checker
  import hz_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                stall,
  input logic                take_raw,
  input logic                flush,
  input logic                pc_we,
  input logic [INSTR_W-1:0]  fd_instr,
  input logic [CTRL_W-1:0]   de_ctrl,
  input logic [REG_W-1:0]    de_rt
);
  AST_STALL_FREEZES_FD: assert property (@(posedge clk) disable iff (!rst_n) stall |=> $stable(fd_instr)); // R2
  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) stall |=> (de_ctrl == ZERO_CTRL)); // R3
  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !stall); // R4
  AST_FLUSH_GIVES_NOP: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (fd_instr == NOP_WORD)); // R7
  AST_FLUSH_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n) flush |-> pc_we); // R7
  AST_ZERO_DEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (de_rt == '0) |-> !stall); // R8
  AST_STALL_OVER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) (stall && take_raw) |-> !flush); // R9
endmodule

bind hazard_ctl_top hz_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stall    (stall_w),
  .take_raw (take_raw_w),
  .flush    (flush_w),
  .pc_we    (pc_we),
  .fd_instr (fd_instr),
  .de_ctrl  (de_ctrl),
  .de_rt    (de_rt)
);

// File: tb/sim_hazard_ctl_top.sv
module sim_hazard_ctl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_instr = '0;
  logic [7:0]  dec_ctrl = '0;
  logic        dec_branch = 1'b0;
  logic        dec_regs_eq = 1'b0;
  logic        pc_we, fd_we, de_ctrl_zero, if_flush;
  logic [31:0] fd_instr;
  logic [7:0]  de_ctrl;
  logic [4:0]  de_rs, de_rt, de_rd;

  int checks = 0;
  int failures = 0;

  // Control words the bench's own decoder would produce.
  localparam logic [7:0] C_LOAD  = 8'b0001_1011; // reg write, mem read, mem-to-reg, immediate
  localparam logic [7:0] C_ALU   = 8'b1010_0001; // reg write, dest select, ALU op 2
  localparam logic [7:0] C_NONE  = 8'h00;

  hazard_ctl_top u0 (
    .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr), .dec_ctrl(dec_ctrl),
    .dec_branch(dec_branch), .dec_regs_eq(dec_regs_eq), .pc_we(pc_we), .fd_we(fd_we),
    .de_ctrl_zero(de_ctrl_zero), .if_flush(if_flush), .fd_instr(fd_instr),
    .de_ctrl(de_ctrl), .de_rs(de_rs), .de_rt(de_rt), .de_rd(de_rd)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] ins(input logic [5:0] op, input logic [4:0] s1,
                                      input logic [4:0] s2, input logic [4:0] d);
    return {op, s1, s2, d, 11'h0a5};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic load_fd(input logic [31:0] w, input logic [7:0] c);
    fetch_instr = w; dec_ctrl = c; dec_branch = 0; dec_regs_eq = 0;
    edge_step();
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10", "fd_instr", fd_instr, 32'h0);
    chk("R10", "de_ctrl", {24'h0, de_ctrl}, 32'h0);
    chk("R10", "pc_we/fd_we/zero/flush", {28'h0, pc_we, fd_we, de_ctrl_zero, if_flush}, 32'hc);
  endtask

  task automatic t_load_use();
    int bubbles = 0;
    logic [31:0] lw_i  = ins(6'h23, 5'd1, 5'd2, 5'd0);
    logic [31:0] and_i = ins(6'h00, 5'd2, 5'd5, 5'd4);
    logic [31:0] or_i  = ins(6'h00, 5'd2, 5'd6, 5'd8);
    load_fd(lw_i, C_NONE);
    load_fd(and_i, C_LOAD);          // de = load rt=2, fd = dependent
    fetch_instr = or_i; dec_ctrl = C_ALU; #1;
    chk("R1", "stall outputs", {29'h0, pc_we, fd_we, de_ctrl_zero}, 32'h1);
    edge_step();
    chk("R2", "fd held", fd_instr, and_i);
    chk("R3", "bubble ctrl", {24'h0, de_ctrl}, 32'h0);
    if (de_ctrl == C_NONE) bubbles++;
    chk("R4", "no second stall", {31'h0, de_ctrl_zero}, 32'h0);
    edge_step();
    chk("R4", "fd advances", fd_instr, or_i);
    chk("R4", "dependent reaches execute", {24'h0, de_ctrl}, {24'h0, C_ALU});
    if (de_ctrl == C_NONE) bubbles++;
    chk("R4", "bubble count", bubbles, 1);
  endtask

  task automatic t_no_dep();
    logic [31:0] nd_i = ins(6'h00, 5'd3, 5'd4, 5'd7);
    logic [31:0] z_i  = ins(6'h00, 5'd0, 5'd9, 5'd10);
    // load to r2, consumer uses r3/r4
    load_fd(ins(6'h23, 5'd1, 5'd2, 5'd0), C_NONE);
    load_fd(nd_i, C_LOAD);
    fetch_instr = 32'h1111_2222; dec_ctrl = C_ALU; #1;
    chk("R5", "no stall unrelated regs", {31'h0, de_ctrl_zero}, 32'h0);
    edge_step();
    chk("R5", "fd advances", fd_instr, 32'h1111_2222);
    chk("R5", "ctrl passes", {24'h0, de_ctrl}, {24'h0, C_ALU});
    // ALU writer to r3 (no memory read), consumer reads r3
    load_fd(ins(6'h00, 5'd8, 5'd3, 5'd3), C_NONE);
    load_fd(ins(6'h00, 5'd3, 5'd3, 5'd11), C_ALU);
    #1;
    chk("R5", "no stall without mem read", {31'h0, de_ctrl_zero}, 32'h0);
    // load to r0, consumer reads r0
    load_fd(ins(6'h23, 5'd1, 5'd0, 5'd0), C_NONE);
    load_fd(z_i, C_LOAD);
    fetch_instr = 32'h3333_4444; #1;
    chk("R8", "r0 never stalls", {30'h0, pc_we, de_ctrl_zero}, 32'h2);
    edge_step();
    chk("R8", "fd advances", fd_instr, 32'h3333_4444);
  endtask

  task automatic t_branch_taken();
    int nops = 0;
    logic [31:0] beq_i = ins(6'h04, 5'd5, 5'd6, 5'd0);
    load_fd(32'h0, C_NONE);
    load_fd(beq_i, C_NONE);
    fetch_instr = 32'h5555_6666; dec_ctrl = C_NONE; dec_branch = 1; dec_regs_eq = 1; #1;
    chk("R7", "flush/pc_we", {30'h0, if_flush, pc_we}, 32'h3);
    edge_step();
    chk("R7", "fd nop", fd_instr, 32'h0);
    if (fd_instr == 32'h0) nops++;
    dec_branch = 0; dec_regs_eq = 0; fetch_instr = 32'h7777_8888; #1;
    chk("R7", "no flush after", {31'h0, if_flush}, 32'h0);
    edge_step();
    chk("R7", "target enters", fd_instr, 32'h7777_8888);
    if (fd_instr == 32'h0) nops++;
    chk("R7", "flushed slots", nops, 1);
  endtask

  task automatic t_branch_not_taken();
    load_fd(ins(6'h04, 5'd5, 5'd6, 5'd0), C_NONE);
    fetch_instr = 32'h9999_aaaa; dec_branch = 1; dec_regs_eq = 0; #1;
    chk("R6", "unequal no flush", {31'h0, if_flush}, 32'h0);
    edge_step();
    chk("R6", "sequential fetch", fd_instr, 32'h9999_aaaa);
    fetch_instr = 32'hbbbb_cccc; dec_branch = 0; dec_regs_eq = 1; #1;
    chk("R6", "equal without branch no flush", {31'h0, if_flush}, 32'h0);
    edge_step();
    chk("R6", "sequential fetch 2", fd_instr, 32'hbbbb_cccc);
  endtask

  task automatic t_priority();
    logic [31:0] beq_i = ins(6'h04, 5'd3, 5'd4, 5'd0);
    load_fd(ins(6'h23, 5'd1, 5'd3, 5'd0), C_NONE);
    load_fd(beq_i, C_LOAD);
    fetch_instr = 32'hdddd_eeee; dec_ctrl = C_NONE; dec_branch = 1; dec_regs_eq = 1; #1;
    chk("R9", "stall wins", {30'h0, de_ctrl_zero, if_flush}, 32'h2);
    edge_step();
    chk("R9", "branch held in decode", fd_instr, beq_i);
    chk("R9", "branch now taken", {31'h0, if_flush}, 32'h1);
    edge_step();
    chk("R9", "fd nop after late flush", fd_instr, 32'h0);
    dec_branch = 0; dec_regs_eq = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_load_use();
        t_no_dep();
        t_branch_taken();
        t_branch_not_taken();
        t_priority();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule